// File: doc/BRIEF.md
# Address-Filtered SPI Slave on a Shared Select Line

This block is a serial slave for a bus on which every slave shares one active-low select line. Each transfer opens with an 8-bit address word. Every slave receives it. Only the slave whose built-in device address equals that word takes part in the rest of the transfer. The other slaves leave their serial output undriven and ignore the clock and data lines until select is released.

The serial lines run in mode 0. Data is sampled on the rising SCLK edge, and the output changes after the falling edge. Words are 8 bits, sent most significant bit first. All serial inputs pass through a synchronizer into the system clock domain, and the whole block runs on that clock.

After a match, the block shows each complete data word on a parallel output together with a one-cycle strobe. It takes the next word to send from a parallel input at fixed points in the transfer. The output enable tells the pad when to drive MISO.

Top module: `addr_spi_slave`

## Requirements
- R1: While reset is active and right after it, `miso_oe_o` and `rx_valid_o` are low.
- R2: The first 8 bits after select goes low form the address word, MSB first, sampled on rising SCLK. A match means that word equals the `DEV_ADDR` parameter.
- R3: `miso_oe_o` stays low while select is high and during all 8 address bits.
- R4: After a match, `miso_oe_o` goes high and `miso_o` presents bit 7 of the transmit word before the first data-phase rising edge. Each later bit appears after a falling edge, MSB first.
- R5: After a match, every 8 data bits received (MSB first) appear on `rx_word_o` with `rx_valid_o` high for exactly one system clock.
- R6: `tx_word_i` is captured at the address match and again at the 8th rising edge of each data word. That captured value becomes the next word shifted out.
- R7: If the address does not match, `miso_oe_o` stays low and `rx_valid_o` never pulses until select goes high.
- R8: Raising select at any point discards a partial word without a strobe and drops `miso_oe_o`. The next select assertion starts again with an address word.
- R9: The block works with an SCLK half-period of 3 or more system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the bus master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Shared active-low select |
| miso_o | output | 1 | Serial data to the master, valid when enabled |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| tx_word_i | input | WORD_W | Next word to transmit |
| rx_word_o | output | WORD_W | Last data word received |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_word_o` |

## Verification
Every serial input reaches the logic through two synchronizer flops and one edge-detect flop. A change in MISO therefore follows the falling SCLK edge that caused it by about three system clocks. The rx strobe follows the 8th rising edge by the same amount.

The bench drives each SCLK half-period for a whole number of system clocks. It reads MISO and the output enable on the last clock before it raises SCLK, which is the point where a mode 0 master would sample. It checks the strobes and words after select has been released for eight clocks, so every pending result has landed by then.

Expected bits and words come from the byte arrays the bench itself sent.

// File: rtl/asps_pkg.sv
package asps_pkg;
  typedef enum logic [1:0] {
    PH_ADDR   = 2'd0,
    PH_DATA   = 2'd1,
    PH_IGNORE = 2'd2
  } phase_t;
endpackage

// File: rtl/asps_sync.sv
module asps_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= rst_val;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= rst_val;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/asps_edge.sv
module asps_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/asps_core.sv
module asps_core
  import asps_pkg::*;
#(
  parameter int              WORD_W   = 8,
  parameter logic [WORD_W-1:0] DEV_ADDR = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              miso_o,
  output logic              oe_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);
  localparam int                CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);

  phase_t             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [WORD_W-1:0]  sh_q, sh_d;
  logic [WORD_W-1:0]  tx_q, tx_d;
  logic [WORD_W-1:0]  rxw_q, rxw_d;
  logic               oe_q, oe_d;
  logic               rxv_q, rxv_d;
  logic [WORD_W-1:0]  sh_next;

  assign sh_next = {sh_q[WORD_W-2:0], mosi_i};

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    rxw_d   = rxw_q;
    oe_d    = oe_q;
    rxv_d   = 1'b0;
    if (!sel_i) begin
      phase_d = PH_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (phase_q)
        PH_ADDR: begin
          if (rise_i) begin
            sh_d  = sh_next;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              cnt_d = '0;
              if (sh_next == DEV_ADDR) begin
                phase_d = PH_DATA;
                oe_d    = 1'b1;
                tx_d    = tx_word_i;
              end else begin
                phase_d = PH_IGNORE;
              end
            end
          end
        end
        PH_DATA: begin
          if (rise_i) begin
            sh_d  = sh_next;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              cnt_d = '0;
              rxw_d = sh_next;
              rxv_d = 1'b1;
              tx_d  = tx_word_i;
            end
          end else if (fall_i && cnt_q != '0) begin
            tx_d = {tx_q[WORD_W-2:0], 1'b0};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      rxw_q   <= '0;
      oe_q    <= 1'b0;
      rxv_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      rxw_q   <= rxw_d;
      oe_q    <= oe_d;
      rxv_q   <= rxv_d;
    end
  end

  assign miso_o     = oe_q & tx_q[WORD_W-1];
  assign oe_o       = oe_q;
  assign rx_word_o  = rxw_q;
  assign rx_valid_o = rxv_q;

  // R3
  addr_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR) |-> !oe_q);
  // R7
  oe_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (phase_q == PH_DATA));
  // R5
  rx_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |=> !rxv_q);
  // R5
  rx_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |-> (phase_q == PH_DATA));
  // R6
  tx_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |-> (tx_q == $past(tx_word_i)));
  // R8
  deselect_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> (!oe_q && phase_q == PH_ADDR && !rxv_q));
endmodule

// File: rtl/addr_spi_slave.sv
module addr_spi_slave #(
  parameter int                WORD_W      = 8,
  parameter logic [WORD_W-1:0] DEV_ADDR    = 8'h5A,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              ss_n_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_valid_o
);
  localparam int NSIG = 3;

  logic [1:0]      rst_sync_q;
  logic            rst_core_n;
  logic [NSIG-1:0] raw, synced;
  logic            sclk_s, mosi_s, ss_n_s, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign raw = {ss_n_i, mosi_i, sclk_i};

  asps_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .rst_val (3'b100),
    .d_i     (raw),
    .q_o     (synced)
  );
  assign {ss_n_s, mosi_s, sclk_s} = synced;

  asps_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .lvl_i  (sclk_s),
    .rise_o (rise),
    .fall_o (fall)
  );

  asps_core #(.WORD_W(WORD_W), .DEV_ADDR(DEV_ADDR)) u_core (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .sel_i      (~ss_n_s),
    .rise_i     (rise),
    .fall_i     (fall),
    .mosi_i     (mosi_s),
    .tx_word_i  (tx_word_i),
    .miso_o     (miso_o),
    .oe_o       (miso_oe_o),
    .rx_word_o  (rx_word_o),
    .rx_valid_o (rx_valid_o)
  );
endmodule

// File: tb/tb_addr_spi_slave.sv
module tb_addr_spi_slave;
  localparam logic [7:0] DEV = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic       miso, oe, rxv;
  logic [7:0] txw = 8'h00, rxw;

  int checks = 0, fails = 0, half = 6;
  logic [7:0] mo [4];
  logic [7:0] tx [4];
  logic [7:0] cap [8];
  int cap_n = 0;
  logic rxv_prev = 1'b0;

  always #4 clk = ~clk;

  addr_spi_slave #(.WORD_W(8), .DEV_ADDR(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .ss_n_i(ss_n),
    .miso_o(miso), .miso_oe_o(oe), .tx_word_i(txw), .rx_word_o(rxw),
    .rx_valid_o(rxv));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // R5: strobe width and word capture
  always @(negedge clk) begin
    if (rxv) begin
      if (cap_n < 8) cap[cap_n] = rxw;
      cap_n++;
    end
    if (rxv && rxv_prev) chk(1'b0, "R5 strobe longer than one clock", 2, 1);
    rxv_prev = rxv;
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_words(input logic [7:0] a, input int nw, input int ab);
    if (a != DEV) return 0;
    if (ab < 0) return nw;
    if (ab < 8) return 0;
    return (ab - 8) / 8;
  endfunction

  task automatic xfer(input logic [7:0] addr, input int nw, input int abort_at);
    int  total = 8 + 8 * nw;
    bit  match = (addr == DEV) && (abort_at < 0 || abort_at >= 8);
    int  ew = exp_words(addr, nw, abort_at);
    cap_n = 0;
    txw = tx[0];
    ss_n = 1'b0;
    mosi = addr[7];
    waitn(half);
    for (int p = 0; p < total; p++) begin
      int k = (p - 8) / 8;
      int b = 7 - (p % 8);
      if (p == abort_at) break;
      mosi = (p < 8) ? addr[b] : mo[k][b];
      if (p >= 8 && b == 3 && k + 1 < nw) txw = tx[k+1];
      waitn(half);
      if (p < 8) chk(oe == 1'b0, "R3 oe during address", oe, 0);
      else if (match) begin
        chk(oe == 1'b1, "R4 oe after match", oe, 1);
        chk(miso == tx[k][b], "R4/R6 miso bit", miso, tx[k][b]);
      end else chk(oe == 1'b0, "R7 oe on mismatch", oe, 0);
      sclk = 1'b1;
      waitn(half);
      sclk = 1'b0;
    end
    ss_n = 1'b1;
    waitn(8);
    chk(oe == 1'b0, "R8 oe after deselect", oe, 0);
    chk(cap_n == ew, (ew == 0) ? "R7/R8 strobe count" : "R5 strobe count", cap_n, ew);
    for (int i = 0; i < ew && i < cap_n; i++)
      chk(cap[i] == mo[i], "R2/R5 received word", cap[i], mo[i]);
  endtask

  task automatic fill(input logic [7:0] base);
    for (int i = 0; i < 4; i++) begin
      mo[i] = base + 8'(i * 37);
      tx[i] = ~base - 8'(i * 19);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    waitn(3);
    chk(oe == 1'b0, "R1 oe in reset", oe, 0);
    chk(rxv == 1'b0, "R1 strobe in reset", rxv, 0);
    rst_n = 1'b1;
    waitn(6);
    chk(oe == 1'b0, "R1 oe after reset", oe, 0);
    chk(rxv == 1'b0, "R1 strobe after reset", rxv, 0);

    fill(8'h81); xfer(DEV, 1, -1);          // R2 R4 R5 single word
    fill(8'h3C); xfer(DEV, 4, -1);          // R6 several words
    fill(8'hC3); xfer(DEV ^ 8'h80, 3, -1);  // R7 MSB differs
    fill(8'h11); xfer(DEV ^ 8'h01, 2, -1);  // R7 LSB differs
    fill(8'hF0); xfer(DEV, 3, 19);          // R8 abort mid data word
    fill(8'h0F); xfer(DEV, 2, 5);           // R8 abort mid address
    fill(8'h66); xfer(DEV, 2, -1);          // R8 restart after abort
    half = 3;
    fill(8'hA5); xfer(DEV, 3, -1);          // R9 fastest SCLK
    half = 6;

    for (int t = 0; t < 24; t++) begin
      logic [7:0] a = ($urandom % 2) ? DEV : 8'($urandom);
      int nw = 1 + ($urandom % 4);
      int ab = (($urandom % 4) == 0) ? int'($urandom % (8 + 8 * nw)) : -1;
      for (int i = 0; i < 4; i++) begin
        mo[i] = 8'($urandom);
        tx[i] = 8'($urandom);
      end
      half = 3 + ($urandom % 5);
      xfer(a, nw, ab);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule